// File: doc/BRIEF.md
# Paged EEPROM Block Write Controller

This block sits on the host side of a byte-wide paged EEPROM. A single start command carries a base address, a byte count and a completion-detection mode. The controller then pulls the bytes from a valid/ready stream and writes each one with its own write-enable pulse. Every byte goes to the same page. Once a byte has been written, the next one must follow within the device's byte-load window, or the device starts programming before the page is complete.

After the last byte, the controller polls the device with read cycles aimed at the last address written. It watches for one of two signs that the internal programming has finished:

- the read byte matches the byte just written, including bit 7, which stays complemented while programming runs;
- bit 6 stops changing between two back-to-back reads.

A timeout bounds the polling. The result comes back as a one-cycle done or error pulse.

All strobe timings are counted in clock cycles and set by parameters: address/data setup, write-enable low time, hold, read width, gap between reads, load window and completion timeout. A request that would cross a page, or has a count of zero or more than one page, is refused before any strobe moves.

Top module: `epw_writer`

## Requirements
- R1: A start whose count is 0, exceeds PAGE_BYTES, or whose base offset (low log2(PAGE_BYTES) address bits) plus count exceeds PAGE_BYTES raises err_o in the cycle after start, leaves busy_o low, and drives no chip-enable low cycle.
- R2: Each byte is written with mem_we_n_o low for exactly PULSE_CYC cycles, while mem_ce_n_o is low, mem_oe_n_o is high and mem_dq_oe_o is high.
- R3: Byte i of a request goes to address base + i and is held unchanged from write-enable fall to rise. The upper address bits above the page offset stay constant while busy.
- R4: s_ready_o is high only while the controller waits for the next byte. Bytes are taken on s_valid_i and s_ready_o both high, and they are written in stream order.
- R5: After a write-enable rise, the next byte must be accepted within WINDOW_CYC cycles. A byte offered on the last legal cycle is accepted. If the window ends without a byte, err_o pulses, the controller goes idle and no further write is issued.
- R6: Poll reads drive mem_ce_n_o low, mem_oe_n_o low and mem_we_n_o high, with mem_dq_oe_o low and the address of the last byte written. Successive reads are separated by GAP_CYC cycles with chip enable high.
- R7: With mode_i = 0 (data polling), done_o pulses only after a poll read returns the last byte written. During programming bit 7 of that read is the complement of the written bit, so completion is never reported then.
- R8: With mode_i = 1 (toggle polling), done_o pulses when bit 6 is equal on two successive poll reads.
- R9: If completion is not seen, err_o pulses exactly HOLD_CYC + TIMEOUT_CYC cycles after the last write-enable rise, and the controller goes idle.
- R10: done_o and err_o are single-cycle pulses, never high together, issued in the first idle cycle.
- R11: Under reset all strobes are high, mem_dq_oe_o, s_ready_o, busy_o, done_o and err_o are low.
- R12: A start pulse while busy_o is high is ignored; the running request completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a request (sampled when idle) |
| base_addr_i | input | ADDR_W | First byte address |
| count_i | input | clog2(PAGE_BYTES+1) | Number of bytes |
| mode_i | input | 1 | 0 = data polling, 1 = toggle polling |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Controller can take a byte |
| mem_addr_o | output | ADDR_W | Device address |
| mem_dq_o | output | 8 | Device write data |
| mem_dq_oe_o | output | 1 | Enable for the data bus driver |
| mem_dq_i | input | 8 | Device read data |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Error pulse (reject, window, timeout) |

## Verification
Two events can land on the same clock edge: the load window running out, and the next stream byte arriving. The bench counts cycles from each observed write-enable rise and offers a byte either on the last legal cycle or one cycle later. The first case must give a complete write ending in done. The second must give err_o with exactly one byte written. A mid-request start with an illegal count probes R12 in the same way: the reject path and the busy path compete, and only the running request may respond.

// File: rtl/epw_pkg.sv
package epw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_GAP,
        ST_READ
    } epw_state_e;

    typedef enum logic {
        POLL_DATA7   = 1'b0,
        POLL_TOGGLE6 = 1'b1
    } epw_poll_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } epw_bus_t;

    // Strobe levels for each controller phase
    function automatic epw_bus_t bus_of(epw_state_e st);
        epw_bus_t b;
        b = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        case (st)
            ST_SETUP, ST_HOLD: begin
                b.ce_n  = 1'b0;
                b.dq_oe = 1'b1;
            end
            ST_PULSE: begin
                b.ce_n  = 1'b0;
                b.we_n  = 1'b0;
                b.dq_oe = 1'b1;
            end
            ST_READ: begin
                b.ce_n = 1'b0;
                b.oe_n = 1'b0;
            end
            default: ;
        endcase
        return b;
    endfunction

    function automatic int max_of5(int a, int b, int c, int d, int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/epw_down_timer.sv
module epw_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/epw_req_check.sv
module epw_req_check #(
    parameter int OFF_W      = 6,
    parameter int CNT_W      = 7,
    parameter int PAGE_BYTES = 64
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [CNT_W-1:0] count,
    output logic             ok
);
    localparam int SW = CNT_W + 1;
    logic [SW-1:0] span;

    assign span = SW'(count) + SW'(offset);
    assign ok   = (count != '0)
               && (count <= CNT_W'(PAGE_BYTES))
               && (span  <= SW'(PAGE_BYTES));
endmodule

// File: rtl/epw_poll_eval.sv
module epw_poll_eval import epw_pkg::*; (
    input  epw_poll_e   mode,
    input  logic [7:0]  rd_data,
    input  logic [7:0]  last_data,
    input  logic        prev_b6,
    input  logic        prev_ok,
    output logic        complete
);
    // Data mode demands the whole byte: bit 7 is inverted while busy,
    // and every bit is true once programming has ended.
    always_comb begin
        if (mode == POLL_DATA7) complete = (rd_data == last_data);
        else                    complete = prev_ok && (rd_data[6] == prev_b6);
    end
endmodule

// File: rtl/epw_writer.sv
module epw_writer import epw_pkg::*; #(
    parameter int ADDR_W      = 15,
    parameter int PAGE_BYTES  = 64,
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 4,
    parameter int HOLD_CYC    = 2,
    parameter int READ_CYC    = 3,
    parameter int GAP_CYC     = 8,
    parameter int WINDOW_CYC  = 37500,
    parameter int TIMEOUT_CYC = 2750000
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_i,
    input  logic [ADDR_W-1:0]                 base_addr_i,
    input  logic [$clog2(PAGE_BYTES+1)-1:0]   count_i,
    input  logic                              mode_i,
    input  logic [7:0]                        s_data_i,
    input  logic                              s_valid_i,
    output logic                              s_ready_o,
    output logic [ADDR_W-1:0]                 mem_addr_o,
    output logic [7:0]                        mem_dq_o,
    output logic                              mem_dq_oe_o,
    input  logic [7:0]                        mem_dq_i,
    output logic                              mem_ce_n_o,
    output logic                              mem_oe_n_o,
    output logic                              mem_we_n_o,
    output logic                              busy_o,
    output logic                              done_o,
    output logic                              err_o
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
    localparam int PG_W   = ADDR_W - OFF_W;
    localparam int PH_MAX = max_of5(SETUP_CYC, PULSE_CYC, HOLD_CYC, READ_CYC, GAP_CYC);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
    localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);

    epw_state_e        state_q, state_d;
    logic [PG_W-1:0]   page_q;
    logic [OFF_W-1:0]  off_q;
    logic [CNT_W-1:0]  cnt_q, idx_q;
    epw_poll_e         mode_q;
    logic [7:0]        data_q;
    logic              prev6_q, prev_ok_q;
    logic              done_q, err_q;

    logic              req_ok, last_byte, complete;
    logic              ph_zero, win_zero, to_zero;
    logic              ph_load, win_load, to_load;
    logic [PH_W-1:0]   ph_val;
    logic              accept_start, take_byte, step_idx, poll_sample;
    logic              done_d, err_d;
    epw_bus_t          bus;

    epw_req_check #(.OFF_W(OFF_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_req (
        .offset (base_addr_i[OFF_W-1:0]),
        .count  (count_i),
        .ok     (req_ok)
    );

    epw_poll_eval u_poll (
        .mode      (mode_q),
        .rd_data   (mem_dq_i),
        .last_data (data_q),
        .prev_b6   (prev6_q),
        .prev_ok   (prev_ok_q),
        .complete  (complete)
    );

    epw_down_timer #(.W(PH_W)) u_phase (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );
    epw_down_timer #(.W(WIN_W)) u_window (
        .clk(clk), .rst(rst), .load(win_load),
        .load_val(WIN_W'(WINDOW_CYC - 1)), .zero(win_zero)
    );
    epw_down_timer #(.W(TO_W)) u_timeout (
        .clk(clk), .rst(rst), .load(to_load),
        .load_val(TO_W'(TIMEOUT_CYC - 1)), .zero(to_zero)
    );

    assign last_byte = (idx_q == cnt_q - 1'b1);

    always_comb begin
        state_d      = state_q;
        ph_load      = 1'b0;
        ph_val       = '0;
        win_load     = 1'b0;
        to_load      = 1'b0;
        accept_start = 1'b0;
        take_byte    = 1'b0;
        step_idx     = 1'b0;
        poll_sample  = 1'b0;
        done_d       = 1'b0;
        err_d        = 1'b0;
        case (state_q)
            ST_IDLE: if (start_i) begin
                if (req_ok) begin
                    accept_start = 1'b1;
                    state_d      = ST_LOAD;
                end else begin
                    err_d = 1'b1;
                end
            end
            ST_LOAD: begin
                if (s_valid_i) begin
                    take_byte = 1'b1;
                    state_d   = ST_SETUP;
                    ph_load   = 1'b1;
                    ph_val    = PH_W'(SETUP_CYC - 1);
                end else if (idx_q != '0 && win_zero) begin
                    err_d   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_SETUP: if (ph_zero) begin
                state_d = ST_PULSE;
                ph_load = 1'b1;
                ph_val  = PH_W'(PULSE_CYC - 1);
            end
            ST_PULSE: if (ph_zero) begin
                state_d  = ST_HOLD;
                ph_load  = 1'b1;
                ph_val   = PH_W'(HOLD_CYC - 1);
                win_load = 1'b1;
            end
            ST_HOLD: if (ph_zero) begin
                if (last_byte) begin
                    state_d = ST_GAP;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(GAP_CYC - 1);
                    to_load = 1'b1;
                end else begin
                    step_idx = 1'b1;
                    state_d  = ST_LOAD;
                end
            end
            ST_GAP: begin
                if (to_zero) begin
                    err_d   = 1'b1;
                    state_d = ST_IDLE;
                end else if (ph_zero) begin
                    state_d = ST_READ;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(READ_CYC - 1);
                end
            end
            ST_READ: begin
                if (ph_zero && complete) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end else if (to_zero) begin
                    err_d   = 1'b1;
                    state_d = ST_IDLE;
                end else if (ph_zero) begin
                    poll_sample = 1'b1;
                    state_d     = ST_GAP;
                    ph_load     = 1'b1;
                    ph_val      = PH_W'(GAP_CYC - 1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            page_q    <= '0;
            off_q     <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
            mode_q    <= POLL_DATA7;
            data_q    <= '0;
            prev6_q   <= 1'b0;
            prev_ok_q <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            err_q   <= err_d;
            if (accept_start) begin
                page_q    <= base_addr_i[ADDR_W-1:OFF_W];
                off_q     <= base_addr_i[OFF_W-1:0];
                cnt_q     <= count_i;
                mode_q    <= epw_poll_e'(mode_i);
                idx_q     <= '0;
                prev_ok_q <= 1'b0;
            end
            if (take_byte) data_q <= s_data_i;
            if (step_idx)  idx_q  <= idx_q + 1'b1;
            if (poll_sample) begin
                prev6_q   <= mem_dq_i[6];
                prev_ok_q <= 1'b1;
            end
        end
    end

    assign bus         = bus_of(state_q);
    assign mem_ce_n_o  = bus.ce_n;
    assign mem_oe_n_o  = bus.oe_n;
    assign mem_we_n_o  = bus.we_n;
    assign mem_dq_oe_o = bus.dq_oe;
    assign mem_dq_o    = data_q;
    assign mem_addr_o  = {page_q, off_q + idx_q[OFF_W-1:0]};
    assign s_ready_o   = (state_q == ST_LOAD);
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;
endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              s_ready_o,
    input logic              mem_ce_n_o,
    input logic              mem_oe_n_o,
    input logic              mem_we_n_o,
    input logic              mem_dq_oe_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    p_reject_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!busy_o && mem_ce_n_o));

    p_we_frame_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n_o |-> (!mem_ce_n_o && mem_oe_n_o && mem_dq_oe_o));

    p_page_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:OFF_W]));

    p_ready_busy_r4: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |-> (busy_o && mem_ce_n_o));

    p_read_frame_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n_o |-> (!mem_ce_n_o && mem_we_n_o && !mem_dq_oe_o));

    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o) |=> !(done_o || err_o));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (mem_ce_n_o && mem_we_n_o && !mem_dq_oe_o && !s_ready_o));
endmodule

bind epw_writer epw_checker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_epw_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .s_ready_o   (s_ready_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .mem_addr_o  (mem_addr_o)
);

// File: tb/tb_epw_writer.sv
`timescale 1ns/1ps
module tb_epw_writer;
    localparam int ADDR_W = 15;
    localparam int PAGE   = 64;
    localparam int SETUP  = 2;
    localparam int PULSE  = 3;
    localparam int HOLD   = 1;
    localparam int READ   = 2;
    localparam int GAP    = 3;
    localparam int WIN    = 40;
    localparam int TMO    = 2000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic [6:0]        count_i = '0;
    logic              mode_i = 1'b0;
    logic [7:0]        s_data_i = '0;
    logic              s_valid_i = 1'b0;
    logic              s_ready_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [7:0]        mem_dq_o;
    logic              mem_dq_oe_o;
    logic [7:0]        mem_dq_i = '0;
    logic              mem_ce_n_o, mem_oe_n_o, mem_we_n_o;
    logic              busy_o, done_o, err_o;

    always #2 clk = ~clk;

    epw_writer #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
        .HOLD_CYC(HOLD), .READ_CYC(READ), .GAP_CYC(GAP),
        .WINDOW_CYC(WIN), .TIMEOUT_CYC(TMO)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .base_addr_i(base_addr_i),
        .count_i(count_i), .mode_i(mode_i), .s_data_i(s_data_i),
        .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .mem_addr_o(mem_addr_o),
        .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i),
        .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Device model and port monitor
    logic [7:0] mem [int];
    int  wr_a[$];
    int  wr_d[$];
    int  wr_cnt = 0, done_cnt = 0, err_cnt = 0, ce_low_cnt = 0;
    int  prog_left = 0, prog_cfg = 100;
    int  cyc = 0, err_cyc = 0, last_rise_cyc = 0;
    int  we_run = 0;
    bit  frame_bad = 0, prev_we = 1, prev_oe = 1, tog = 0, cur_mode = 0;
    logic [ADDR_W-1:0] fall_addr = '0, last_wr_addr = '0;
    logic [7:0]        last_wr_data = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (done_o) begin
                done_cnt++;
                chk(prog_left == 0, cur_mode ? "R8 done only after programming"
                                             : "R7 done only after programming", prog_left, 0);
            end
            if (err_o) begin
                err_cnt++;
                err_cyc = cyc;
            end
            if (!mem_ce_n_o) ce_low_cnt++;
            if (!mem_we_n_o) begin
                if (prev_we) begin
                    fall_addr = mem_addr_o;
                    frame_bad = 0;
                    we_run    = 0;
                end
                we_run++;
                if (mem_ce_n_o || !mem_oe_n_o || !mem_dq_oe_o) frame_bad = 1;
            end else if (!prev_we) begin
                chk(we_run == PULSE, "R2 write-enable low width", we_run, PULSE);
                chk(!frame_bad, "R2 strobe frame during write", int'(frame_bad), 0);
                chk(mem_addr_o == fall_addr, "R3 address held across write", mem_addr_o, fall_addr);
                mem[int'(mem_addr_o)] = mem_dq_o;
                wr_a.push_back(int'(mem_addr_o));
                wr_d.push_back(int'(mem_dq_o));
                wr_cnt++;
                last_wr_addr  = mem_addr_o;
                last_wr_data  = mem_dq_o;
                prog_left     = prog_cfg;
                last_rise_cyc = cyc;
            end
            if (!mem_oe_n_o && prev_oe) begin
                tog = ~tog;
                chk(!mem_ce_n_o && mem_we_n_o && !mem_dq_oe_o && (mem_addr_o == last_wr_addr),
                    "R6 poll read frame and address", mem_addr_o, last_wr_addr);
            end
            prev_we = mem_we_n_o;
            prev_oe = mem_oe_n_o;
            if (prog_left > 0) prog_left--;
            if (prog_left > 0)
                mem_dq_i = {~last_wr_data[7], tog, last_wr_data[5:0]};
            else if (mem.exists(int'(mem_addr_o)))
                mem_dq_i = mem[int'(mem_addr_o)];
            else
                mem_dq_i = 8'hFF;
        end
    end

    task automatic reject_case(input int base, input int cnt, input string tag);
        int c0;
        @(negedge clk);
        c0 = ce_low_cnt;
        base_addr_i = ADDR_W'(base);
        count_i     = 7'(cnt);
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o == 1'b1, {tag, " err pulse"}, int'(err_o), 1);
        chk(busy_o == 1'b0, {tag, " stays idle"}, int'(busy_o), 0);
        repeat (8) @(negedge clk);
        chk(ce_low_cnt == c0, {tag, " no strobes"}, ce_low_cnt - c0, 0);
        chk(s_ready_o == 1'b0, {tag, " no stream ready"}, int'(s_ready_o), 0);
    endtask

    // kidx/kval: byte index whose delay after the previous write is forced
    task automatic run_op(input int base, input int cnt, input bit mode, input int prog,
                          input int kidx, input int kval, input bit inject,
                          input bit exp_ok, input int exp_wr, input string tag);
        logic [7:0] bytes [64];
        int d0, e0, guard, k;
        for (int i = 0; i < 64; i++) bytes[i] = 8'($urandom);
        wr_a.delete();
        wr_d.delete();
        wr_cnt   = 0;
        prog_cfg = prog;
        cur_mode = mode;
        d0 = done_cnt;
        e0 = err_cnt;
        @(negedge clk);
        base_addr_i = ADDR_W'(base);
        count_i     = 7'(cnt);
        mode_i      = mode;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            if (i > 0) begin
                while (wr_cnt < i && busy_o) begin
                    @(negedge clk);
                    #1;
                end
                if (!busy_o) break;
                k = (i == kidx) ? kval : int'($urandom_range(0, 8));
                repeat (k) @(negedge clk);
            end
            s_data_i  = bytes[i];
            s_valid_i = 1'b1;
            while (1) begin
                if (!busy_o) break;
                if (s_ready_o) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
            s_valid_i = 1'b0;
            if (inject && i == 0) begin
                // R12: illegal start while busy must be ignored
                start_i = 1'b1;
                count_i = 7'd0;
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        guard = 0;
        while (done_cnt == d0 && err_cnt == e0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (exp_ok) begin
            chk(done_cnt == d0 + 1, {tag, " done pulse"}, done_cnt - d0, 1);
            chk(err_cnt == e0, {tag, " no error"}, err_cnt - e0, 0);
            chk(wr_a.size() == cnt, {tag, " R4 byte count written"}, wr_a.size(), cnt);
            for (int i = 0; i < cnt && i < wr_a.size(); i++) begin
                chk(wr_a[i] == base + i, {tag, " R3 byte address"}, wr_a[i], base + i);
                chk(wr_d[i] == int'(bytes[i]), {tag, " R4 byte data order"}, wr_d[i], int'(bytes[i]));
            end
        end else begin
            chk(err_cnt == e0 + 1, {tag, " error pulse"}, err_cnt - e0, 1);
            chk(done_cnt == d0, {tag, " no done"}, done_cnt - d0, 0);
            chk(wr_a.size() == exp_wr, {tag, " bytes written before abort"}, wr_a.size(), exp_wr);
        end
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0, {tag, " back to idle"}, int'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int b, off, cnt;
        void'($urandom(32'h5EED_0A1C));
        repeat (5) @(negedge clk);
        // R11 reset state
        chk(mem_ce_n_o && mem_oe_n_o && mem_we_n_o, "R11 strobes high in reset", 0, 1);
        chk(!mem_dq_oe_o && !s_ready_o, "R11 bus and ready idle in reset", int'(mem_dq_oe_o), 0);
        chk(!busy_o && !done_o && !err_o, "R11 status low in reset", int'(busy_o), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        reject_case(16'h0000, 0,  "R1 zero count");
        reject_case(16'h0100, 65, "R1 count above page");
        reject_case(16'h013C, 5,  "R1 page crossing");

        run_op(16'h0040, 64, 1'b0, 200, -1, 0, 1'b0, 1'b1, 0, "R3 full page R7");
        run_op(16'h00BF, 1,  1'b0, 60,  -1, 0, 1'b0, 1'b1, 0, "R3 last offset single byte");
        run_op(16'h1204, 9,  1'b1, 150, -1, 0, 1'b0, 1'b1, 0, "R8 toggle mode");
        run_op(16'h2200, 3,  1'b0, 80,  1, WIN - 1, 1'b0, 1'b1, 0, "R5 byte on last legal cycle");
        run_op(16'h2300, 3,  1'b0, 80,  1, WIN,     1'b0, 1'b0, 1, "R5 window expired");
        run_op(16'h0A10, 4,  1'b1, 90,  -1, 0, 1'b1, 1'b1, 0, "R12 start while busy");
        run_op(16'h3340, 2,  1'b0, 100000, -1, 0, 1'b0, 1'b0, 2, "R9 timeout");
        chk(err_cyc - last_rise_cyc == HOLD + TMO, "R9 timeout instant",
            err_cyc - last_rise_cyc, HOLD + TMO);
        repeat (10) @(negedge clk);
        run_op(16'h3380, 2,  1'b0, 40,  -1, 0, 1'b0, 1'b1, 0, "R10 recovery after timeout");

        for (int n = 0; n < 12; n++) begin
            b   = int'($urandom_range(0, 511)) * PAGE;
            off = int'($urandom_range(0, 63));
            cnt = int'($urandom_range(1, 64 - off));
            run_op(b + off, cnt, 1'($urandom_range(0, 1)), int'($urandom_range(20, 300)),
                   -1, 0, 1'b0, 1'b1, 0, "random op");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule